// File: doc/BRIEF.md
# Output-Stationary 3x3 Systolic Matrix Multiplier

This block multiplies two 3x3 matrices of signed integers on a three-by-three grid of processing cells. Each cell keeps its result in its own accumulator. Left-matrix operands enter along the rows and right-matrix operands enter along the columns. Each operand moves one cell right or one cell down per cycle, through a register.

The caller places both matrices on flat input buses and pulses `start` for one cycle. On that edge the block captures the operands and clears the accumulators. An internal sequencer then feeds the row and column edges in skewed order: row i runs i cycles late and column j runs j cycles late, so each pair that belongs together meets in the right cell. Any edge slot with no scheduled operand carries zero.

After seven accumulate cycles, `done` rises. The nine products then stay on `c_flat` until the next start.

Top module: `sysmm3`

## Requirements
- R1: When `done` is high, the result at row i, column j equals the signed sum over k of a[i][k]*b[k][j], taken from the operands captured at the last start.
- R2: The results do not overflow, even when every operand is the most negative W-bit value; each result is 2W+2 bits wide.
- R3: Element (i,j) of A sits at `a_flat[(3*i+j)*W +: W]` and the same rule applies to B. Result (i,j) sits at `c_flat[(3*i+j)*(2W+2) +: 2W+2]`.
- R4: On the cycle after `start` is sampled, `busy` is 1, `done` is 0 and every result reads zero.
- R5: `done` rises exactly 7 clock edges after the edge that samples `start`. `busy` stays high through the edges in between, and `busy` and `done` are never high together.
- R6: While `done` is high and no start arrives, `done` and `c_flat` stay unchanged. Changes on `a_flat` or `b_flat` in that time have no effect.
- R7: A start that arrives while `busy` is high restarts the computation with the newly captured operands.
- R8: After reset, `busy` and `done` are 0 and all results read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse: capture operands, clear, begin |
| a_flat | input | 9*W | Left matrix, row-major |
| b_flat | input | 9*W | Right matrix, row-major |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results valid and held |
| c_flat | output | 9*(2W+2) | Product matrix, row-major |

## Verification
Some rules are checked by assertions on every cycle:
- `busy` and `done` are never both high.
- `done` follows the final accumulate step.
- A start clears the results.
- Results hold while `done` is high.

The numeric correctness of the products needs the bench's scenarios. These cover the skew alignment, zero-filled edges, signed extremes and the restart case, compared against a reference product.

// File: rtl/sysmm3.sv
module sysmm3 #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [9*W-1:0]        a_flat,
  input  logic [9*W-1:0]        b_flat,
  output logic                  busy,
  output logic                  done,
  output logic [9*(2*W+2)-1:0]  c_flat
);
  localparam int N    = 3;
  localparam int AW   = 2*W + 2;
  localparam int LAST = 3*(N-1);
  localparam int SW   = $clog2(LAST+1);

  logic signed [W-1:0]  am   [N][N];
  logic signed [W-1:0]  bm   [N][N];
  logic signed [W-1:0]  hreg [N][N];
  logic signed [W-1:0]  vreg [N][N];
  logic signed [W-1:0]  m_in [N][N];
  logic signed [W-1:0]  n_in [N][N];
  logic signed [AW-1:0] acc  [N][N];
  logic signed [W-1:0]  row_edge [N];
  logic signed [W-1:0]  col_edge [N];
  logic [SW-1:0] step;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      row_edge[i] = '0;
      col_edge[i] = '0;
      for (int k = 0; k < N; k++) begin
        if (busy && int'(step) == i + k) begin
          row_edge[i] = am[i][k];
          col_edge[i] = bm[k][i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      step <= '0;
    end else if (busy) begin
      if (int'(step) == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      step <= step + 1'b1;
    end
  end

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_row
      for (gj = 0; gj < N; gj++) begin : g_col
        if (gj == 0) begin : g_w
          assign m_in[gi][gj] = row_edge[gi];
        end else begin : g_h
          assign m_in[gi][gj] = hreg[gi][gj-1];
        end
        if (gi == 0) begin : g_n
          assign n_in[gi][gj] = col_edge[gj];
        end else begin : g_v
          assign n_in[gi][gj] = vreg[gi-1][gj];
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            am[gi][gj]   <= '0;
            bm[gi][gj]   <= '0;
            hreg[gi][gj] <= '0;
            vreg[gi][gj] <= '0;
            acc[gi][gj]  <= '0;
          end else if (start) begin
            am[gi][gj]   <= a_flat[(N*gi+gj)*W +: W];
            bm[gi][gj]   <= b_flat[(N*gi+gj)*W +: W];
            hreg[gi][gj] <= '0;
            vreg[gi][gj] <= '0;
            acc[gi][gj]  <= '0;
          end else if (busy) begin
            hreg[gi][gj] <= m_in[gi][gj];
            vreg[gi][gj] <= n_in[gi][gj];
            acc[gi][gj]  <= acc[gi][gj] + AW'(m_in[gi][gj] * n_in[gi][gj]);
          end
        end

        assign c_flat[(N*gi+gj)*AW +: AW] = acc[gi][gj];
      end
    end
  endgenerate

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(step) == LAST && !start) |=> (done && !busy));
  p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && c_flat == '0));
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(c_flat)));
endmodule

// File: tb/sysmm3_tb.sv
module sysmm3_tb;
  localparam int W  = 8;
  localparam int AW = 2*W + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [9*W-1:0] a_flat = '0, b_flat = '0;
  logic busy, done;
  logic [9*AW-1:0] c_flat;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sysmm3 #(.W(W)) u_dut (.clk, .rst_n, .start, .a_flat, .b_flat,
                         .busy, .done, .c_flat);

  function automatic logic [9*AW-1:0] ref_mm(input logic [9*W-1:0] a,
                                             input logic [9*W-1:0] b);
    logic [9*AW-1:0] r = '0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        int s = 0;
        for (int k = 0; k < 3; k++)
          s += int'($signed(a[(3*i+k)*W +: W])) * int'($signed(b[(3*k+j)*W +: W]));
        r[(3*i+j)*AW +: AW] = AW'(s);
      end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [9*AW-1:0] act,
                     input logic [9*AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run(input logic [9*W-1:0] a, input logic [9*W-1:0] b, input string req);
    logic [9*AW-1:0] exp;
    a_flat = a; b_flat = b;
    exp = ref_mm(a, b);
    pulse_start();
    chk(busy && !done && c_flat == '0, "R4", c_flat, '0);
    repeat (6) @(negedge clk);
    chk(busy && !done, "R5", {busy, done}, 2'b10);
    @(negedge clk);
    chk(done && !busy, "R5", {busy, done}, 2'b01);
    chk(c_flat == exp, req, c_flat, exp);
    a_flat = {$urandom, $urandom, $urandom};
    b_flat = {$urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(done && c_flat == exp, "R6", c_flat, exp);
  endtask

  initial begin
    logic [9*W-1:0] ia, ib, ta, tb2;
    logic [9*AW-1:0] e;
    void'($urandom(32'd1447));
    repeat (3) @(negedge clk);
    chk(!busy && !done && c_flat == '0, "R8", c_flat, '0);
    rst_n = 1;
    @(negedge clk);
    ia = '0; ib = '0;
    for (int i = 0; i < 3; i++) begin
      ia[(4*i)*W +: W] = 8'd1;
      ib[(4*i)*W +: W] = 8'd1;
    end
    run(ia, ib, "R1");
    for (int n = 0; n < 9; n++) begin
      ia[n*W +: W] = W'(n + 1);
      ib[n*W +: W] = W'(10 * (n + 1));
    end
    run(ia, ib, "R3");
    run({9{8'h80}}, {9{8'h80}}, "R2");
    run({9{8'h7f}}, {9{8'h80}}, "R2");
    run({9{8'hff}}, {9{8'h7f}}, "R2");
    for (int t = 0; t < 25; t++)
      run({$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom}, "R1");
    ta = {$urandom, $urandom, $urandom};
    tb2 = {$urandom, $urandom, $urandom};
    a_flat = {$urandom, $urandom, $urandom};
    b_flat = {$urandom, $urandom, $urandom};
    pulse_start();
    repeat (3) @(negedge clk);
    a_flat = ta; b_flat = tb2;
    e = ref_mm(ta, tb2);
    pulse_start();
    chk(busy && c_flat == '0, "R7", c_flat, '0);
    repeat (6) @(negedge clk);
    chk(busy && !done, "R7", {busy, done}, 2'b10);
    @(negedge clk);
    chk(done && c_flat == e, "R7", c_flat, e);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule